// File: doc/BRIEF.md
# Mode-Selectable Decimal/Binary Digit Adder

This block adds two 4-bit operand digits and a carry-in. A single mode input picks the kind of sum at run time. With the mode low, the block gives the plain binary sum as four result bits and a carry-out. With the mode high, it treats both operands as decimal digits and corrects the raw sum into a valid decimal digit with a decimal carry-out. The carry-in lets digits be cascaded.

The datapath is one ripple adder followed by a decimal fix-up stage, which reuses the same adder cell to add six. A registered output stage is selected by a parameter and is on by default. When it is on, the result of the operands presented before a rising clock edge appears right after that edge. A synchronous, active-high reset clears the stage.

Top module: `modal_digit_adder`

## Requirements
- R1: While `rst` is high at a rising clock edge, the outputs become `sum = 0` and `cout = 0` after that edge, whatever the other inputs are.
- R2: With the default registered stage, the outputs change only at a rising clock edge. Inputs changed between edges leave `sum` and `cout` untouched until the next edge, which loads the result for the inputs present at that edge.
- R3: With `mode_dec = 0`, `{cout, sum}` equals the 5-bit value `opa + opb + cin`, with no correction.
- R4: With `mode_dec = 1`, when the raw sum `opa + opb + cin` is 9 or less, `sum` equals the raw sum and `cout = 0`.
- R5: With `mode_dec = 1` and both operands in 0 to 9, a raw sum from 10 to 19 gives `sum = raw - 10` and `cout = 1`, so `sum` is always a valid digit in 0 to 9.
- R6: `cin` adds exactly one to the raw sum in both modes. For example, 9 + 9 + 1 gives `sum = 9`, `cout = 1` in decimal mode, and 15 + 15 + 1 gives `sum = 15`, `cout = 1` in binary mode.
- R7: With `mode_dec = 1`, any raw sum above 9, including sums from operands above 9, gives `sum = (raw + 6) mod 16` and `cout = 1`. The block does not flag such operands.
- R8: `mode_dec` is captured together with the operands. Changing it from one clock edge to the next, with the operands held, changes the result at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the output stage |
| mode_dec | input | 1 | 1 = decimal digit addition, 0 = binary addition |
| opa | input | 4 | First operand digit |
| opb | input | 4 | Second operand digit |
| cin | input | 1 | Carry-in from a lower digit |
| sum | output | 4 | Result digit |
| cout | output | 1 | Carry-out (binary or decimal, per mode) |

## Verification
Every combination of both operands and the carry-in is driven in each mode. In binary mode this separates a correct carry chain from one with a stuck or dropped carry. In decimal mode it separates sums that need no correction, in-range sums that must wrap by ten, and out-of-range operand sums that still follow the add-six rule. The same operands are then driven with the mode toggled on successive edges, which shows the mode is captured with the data. Inputs are also changed between edges to show that the output waits for the clock, and a reset is asserted mid-stream to show that the stage clears.

// File: rtl/mdadd_pkg.sv
package mdadd_pkg;
  localparam int DIGIT_W   = 4;
  localparam int DEC_LIMIT = 9;
  localparam int DEC_ADJ   = 6;

  typedef enum logic {
    MODE_BIN = 1'b0,
    MODE_DEC = 1'b1
  } add_mode_t;

  typedef struct packed {
    logic               carry;
    logic [DIGIT_W-1:0] value;
  } digit_res_t;
endpackage

// File: rtl/mdadd_ripple.sv
module mdadd_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] c;

  assign c[0] = ci;

  generate
    for (genvar i = 0; i < W; i++) begin : g_cell
      logic p;
      assign p      = a[i] ^ b[i];
      assign s[i]   = p ^ c[i];
      assign c[i+1] = (a[i] & b[i]) | (p & c[i]);
    end
  endgenerate

  assign co = c[W];
endmodule

// File: rtl/mdadd_dec_fix.sv
module mdadd_dec_fix
  import mdadd_pkg::*;
(
  input  logic [DIGIT_W-1:0] raw_s,
  input  logic               raw_c,
  input  add_mode_t          mode,
  output digit_res_t         res
);
  localparam logic [DIGIT_W-1:0] ADJ_K = DIGIT_W'(DEC_ADJ);
  localparam logic [DIGIT_W-1:0] LIM_K = DIGIT_W'(DEC_LIMIT);

  logic               over;
  logic [DIGIT_W-1:0] adj_s;
  logic               adj_carry_unused;

  // the raw sum exceeds one decimal digit
  assign over = raw_c | (raw_s > LIM_K);

  mdadd_ripple #(.W(DIGIT_W)) u_adj (
    .a  (raw_s),
    .b  (ADJ_K),
    .ci (1'b0),
    .s  (adj_s),
    .co (adj_carry_unused)
  );

  always_comb begin
    if (mode == MODE_DEC) begin
      res.carry = over;
      res.value = over ? adj_s : raw_s;
    end else begin
      res.carry = raw_c;
      res.value = raw_s;
    end
  end
endmodule

// File: rtl/mdadd_out_stage.sv
module mdadd_out_stage
  import mdadd_pkg::*;
#(
  parameter bit REG = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  digit_res_t d,
  output digit_res_t q
);
  generate
    if (REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
      end
    end else begin : g_pass
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/modal_digit_adder.sv
module modal_digit_adder
  import mdadd_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mode_dec,
  input  logic [DIGIT_W-1:0] opa,
  input  logic [DIGIT_W-1:0] opb,
  input  logic               cin,
  output logic [DIGIT_W-1:0] sum,
  output logic               cout
);
  add_mode_t          mode;
  logic [DIGIT_W-1:0] raw_s;
  logic               raw_c;
  digit_res_t         comb_res;
  digit_res_t         out_res;

  assign mode = add_mode_t'(mode_dec);

  mdadd_ripple #(.W(DIGIT_W)) u_add (
    .a  (opa),
    .b  (opb),
    .ci (cin),
    .s  (raw_s),
    .co (raw_c)
  );

  mdadd_dec_fix u_fix (
    .raw_s (raw_s),
    .raw_c (raw_c),
    .mode  (mode),
    .res   (comb_res)
  );

  mdadd_out_stage #(.REG(OUT_REG)) u_out (
    .clk (clk),
    .rst (rst),
    .d   (comb_res),
    .q   (out_res)
  );

  assign sum  = out_res.value;
  assign cout = out_res.carry;

  generate
    if (OUT_REG) begin : g_chk
      logic [DIGIT_W:0] chk_raw;
      assign chk_raw = {1'b0, opa} + {1'b0, opb} + {{DIGIT_W{1'b0}}, cin};

      assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (sum == '0 && !cout));

      assert_bin_plain_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(mode_dec)) |-> ({cout, sum} == $past(chk_raw)));

      assert_dec_small_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode_dec) && $past(chk_raw) <= (DIGIT_W+1)'(DEC_LIMIT))
        |-> (!cout && {1'b0, sum} == $past(chk_raw)));

      assert_dec_digit_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode_dec) && $past(opa) <= DIGIT_W'(DEC_LIMIT)
         && $past(opb) <= DIGIT_W'(DEC_LIMIT))
        |-> (sum <= DIGIT_W'(DEC_LIMIT)));

      assert_dec_carry_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode_dec) && $past(chk_raw) > (DIGIT_W+1)'(DEC_LIMIT))
        |-> cout);
    end
  endgenerate
endmodule

// File: tb/modal_digit_adder_test.sv
module modal_digit_adder_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_dec = 1'b0;
  logic [3:0] opa = '0;
  logic [3:0] opb = '0;
  logic       cin = 1'b0;
  logic [3:0] sum;
  logic       cout;

  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  modal_digit_adder uut (
    .clk(clk), .rst(rst), .mode_dec(mode_dec),
    .opa(opa), .opb(opb), .cin(cin),
    .sum(sum), .cout(cout)
  );

  function automatic int ref_model(int m, int a, int b, int c);
    int raw;
    raw = a + b + c;
    if (m == 1 && raw > 9) return 16 + ((raw + 6) % 16);
    if (m == 1) return raw;
    return raw % 32;
  endfunction

  task automatic check(int exp_s, int exp_c, string req);
    compared++;
    if (sum !== 4'(exp_s) || cout !== 1'(exp_c)) begin
      mismatched++;
      $display("FAIL %s: got sum=%0d cout=%0b, expected sum=%0d cout=%0d",
               req, sum, cout, exp_s, exp_c);
    end
  endtask

  // drive away from the edge, let one edge pass, sample after it
  task automatic apply(int m, int a, int b, int c);
    @(negedge clk);
    mode_dec = 1'(m); opa = 4'(a); opb = 4'(b); cin = 1'(c);
    @(posedge clk);
    #1;
  endtask

  task automatic apply_check(int m, int a, int b, int c, string req);
    int e;
    apply(m, a, b, c);
    e = ref_model(m, a, b, c);
    check(e % 16, e / 16, req);
  endtask

  initial begin
    #(200000 * 10);
    mismatched++;
    $display("FAIL watchdog: got no finish, expected finish before timeout");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    string tag;
    // R1: reset state with nonzero inputs held
    mode_dec = 1'b1; opa = 4'd9; opb = 4'd9; cin = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check(0, 0, "R1");
    @(negedge clk);
    rst = 1'b0;

    // exhaustive sweep in both modes
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 2; c++)
        for (int a = 0; a < 16; a++)
          for (int b = 0; b < 16; b++) begin
            if (m == 0) tag = "R3";
            else if (a + b + c <= 9) tag = "R4";
            else if (a <= 9 && b <= 9) tag = "R5";
            else tag = "R7";
            apply_check(m, a, b, c, tag);
          end

    // R6: carry-in corner cases
    apply_check(1, 9, 9, 1, "R6");
    check(9, 1, "R6");
    apply_check(0, 15, 15, 1, "R6");
    check(15, 1, "R6");
    apply_check(1, 4, 5, 1, "R6");
    check(0, 1, "R6");
    apply_check(1, 4, 5, 0, "R4");
    check(9, 0, "R4");

    // R8: mode toggled each edge with the operands held
    for (int k = 0; k < 6; k++) begin
      apply_check(k % 2, 8, 7, 0, "R8");
      check((k % 2) ? 5 : 15, (k % 2) ? 1 : 0, "R8");
    end

    // R2: the output holds between edges
    apply(0, 3, 4, 0);
    check(7, 0, "R2");
    mode_dec = 1'b1; opa = 4'd9; opb = 4'd8; cin = 1'b1;
    #2;
    check(7, 0, "R2");
    @(posedge clk);
    #1;
    check(8, 1, "R2");

    // R1: reset mid-stream
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check(0, 0, "R1");
    @(negedge clk);
    rst = 1'b0;
    apply_check(0, 1, 2, 0, "R3");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule